// File: doc/BRIEF.md
# Saturating Eight-Deep Return Stack

This block is a small last-in, first-out store that a processor core uses for return addresses or for pushed data. It is built from a chain of registers with no pointer. A push moves every word one place deeper and writes the new word into the top place. A pop moves every word one place toward the top. The deepest place keeps its own value during a pop, so it fills upward as the stack drains.

The stack has no full, empty or fault flags. When it is full, a push drops the oldest word without any signal. When it is empty, a pop returns the deepest value again, and it goes on returning that value for as long as pops continue. The top word is always visible on the pop output with no register in between. A pop strobe only moves the words at the next clock edge. When push and pop are both asserted in the same cycle, the top word is overwritten and the other words stay where they are. The reset input is asynchronous and active-low. The block releases it internally in step with the clock.

Top module: `lifo_stack`

## Requirements
- R1: While reset is applied, every stack place holds zero. After reset, pops with no push in between give a pop output of zero.
- R2: A push with no pop writes push_data into the top place. The value appears on pop_data after that clock edge.
- R3: A pop with no push moves each place up by one. Words come back in the reverse of the order in which they were pushed.
- R4: When all DEPTH places hold pushed words, a further push discards the oldest word. The other words keep their order, one place deeper.
- R5: During a pop, the deepest place keeps its value. Once the stack is drained, every further pop returns the deepest value again.
- R6: When push and pop are asserted in the same cycle, only the top place is replaced by push_data. Every deeper place is unchanged.
- R7: In a cycle with neither push nor pop, no place changes.
- R8: pop_data shows the current top place with no register delay. This includes the cycle in which the pop strobe is high.
- R9: Asserting rst_n clears the stack at once, with no clock edge. After rst_n is released, strobes in the first two clock edges are ignored. A push at the third edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| push_en | input | 1 | Push strobe |
| pop_en | input | 1 | Pop strobe |
| push_data | input | WIDTH | Word to push |
| pop_data | output | WIDTH | Current top word |

## Verification
The bench builds two copies of the block. The first uses the default eight places of 22 bits. It runs directed sequences: twelve pushes followed by twelve pops, so overflow, drain and repeated underflow all happen in one run with values the bench computes from the push index. It also covers same-cycle push and pop, idle hold, and the reset release latency. The second copy has three places of 4 bits. It is driven with twenty thousand pseudo-random operations and compared every cycle against a shift model, so a short stack reaches the full, empty and mixed-operation orderings many times over.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;

  // Stack operation decoded from the two strobes {pop, push}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/lifo_rst_sync.sv
module lifo_rst_sync
  import lifo_stack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);

  logic [RST_SYNC_STAGES-1:0] sync_q;
  logic [RST_SYNC_STAGES-1:0] sync_d;

  // Shift a one in from the bottom after release
  always_comb begin
    sync_d = {sync_q[RST_SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign core_rst_n = sync_q[RST_SYNC_STAGES-1];

endmodule

// File: rtl/lifo_op_decode.sv
module lifo_op_decode
  import lifo_stack_pkg::*;
(
  input  logic    push_en,
  input  logic    pop_en,
  output stk_op_e op
);

  always_comb begin
    case ({pop_en, push_en})
      2'b01:   op = OP_PUSH;
      2'b10:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_IDLE;
    endcase
  end

endmodule

// File: rtl/lifo_entry.sv
module lifo_entry
  import lifo_stack_pkg::*;
#(
  parameter int unsigned WIDTH  = 22,
  parameter bit          IS_TOP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic [WIDTH-1:0] push_data,
  input  logic [WIDTH-1:0] from_above,
  input  logic [WIDTH-1:0] from_below,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] nxt;
  logic             en;

  // Next-state select and clock enable
  always_comb begin
    nxt = q;
    en  = 1'b0;
    case (op)
      OP_PUSH: begin
        nxt = from_above;
        en  = 1'b1;
      end
      OP_POP: begin
        nxt = from_below;
        en  = 1'b1;
      end
      OP_SWAP: begin
        if (IS_TOP) begin
          nxt = push_data;
          en  = 1'b1;
        end
      end
      default: begin
        nxt = q;
        en  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import lifo_stack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] pop_data
);

  localparam int unsigned FLAT_W = DEPTH * WIDTH;

  logic                core_rst_n;
  stk_op_e             op;
  logic [WIDTH-1:0]    ent [DEPTH];
  logic [FLAT_W-1:0]   stk_flat;

  lifo_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  lifo_op_decode u_decode (
    .push_en (push_en),
    .pop_en  (pop_en),
    .op      (op)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WIDTH-1:0] above;
    logic [WIDTH-1:0] below;

    if (i == 0) begin : g_top
      assign above = push_data;
    end else begin : g_mid_a
      assign above = ent[i-1];
    end

    if (i == DEPTH - 1) begin : g_bot
      assign below = ent[i];
    end else begin : g_mid_b
      assign below = ent[i+1];
    end

    lifo_entry #(
      .WIDTH  (WIDTH),
      .IS_TOP (i == 0)
    ) u_entry (
      .clk        (clk),
      .rst_n      (core_rst_n),
      .op         (op),
      .push_data  (push_data),
      .from_above (above),
      .from_below (below),
      .q          (ent[i])
    );

    assign stk_flat[i*WIDTH +: WIDTH] = ent[i];
  end

  assign pop_data = ent[0];

endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 22
) (
  input logic                   clk,
  input logic                   core_rst_n,
  input logic                   push_en,
  input logic                   pop_en,
  input logic [WIDTH-1:0]       push_data,
  input logic [WIDTH-1:0]       pop_data,
  input logic [DEPTH*WIDTH-1:0] stk_flat
);

  localparam int unsigned LAST = DEPTH - 1;

  // R1: the stack is all zero while the internal reset is low
  a_r1_reset_clear: assert property (@(posedge clk)
    !core_rst_n |-> stk_flat == '0);

  // R2: a plain push shows its data on top after the edge
  a_r2_push_top: assert property (@(posedge clk) disable iff (!core_rst_n)
    (push_en && !pop_en) |=> pop_data == $past(push_data));

  // R4: a plain push moves the next-to-last place into the deepest place
  a_r4_push_shift: assert property (@(posedge clk) disable iff (!core_rst_n)
    (push_en && !pop_en) |=>
      stk_flat[LAST*WIDTH +: WIDTH] == $past(stk_flat[(LAST-1)*WIDTH +: WIDTH]));

  // R3: a plain pop brings the second place to the top
  a_r3_pop_shift: assert property (@(posedge clk) disable iff (!core_rst_n)
    (pop_en && !push_en) |=> pop_data == $past(stk_flat[WIDTH +: WIDTH]));

  // R5: the deepest place holds its value during a pop
  a_r5_bottom_keep: assert property (@(posedge clk) disable iff (!core_rst_n)
    (pop_en && !push_en) |=> $stable(stk_flat[LAST*WIDTH +: WIDTH]));

  // R6: push with pop replaces only the top place
  a_r6_swap_top: assert property (@(posedge clk) disable iff (!core_rst_n)
    (pop_en && push_en) |=> pop_data == $past(push_data));
  a_r6_swap_rest: assert property (@(posedge clk) disable iff (!core_rst_n)
    (pop_en && push_en) |=> $stable(stk_flat[DEPTH*WIDTH-1:WIDTH]));

  // R7: idle cycles change nothing
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!pop_en && !push_en) |=> $stable(stk_flat));

endmodule

bind lifo_stack lifo_stack_chk #(
  .DEPTH (DEPTH),
  .WIDTH (WIDTH)
) chk_i (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .push_en    (push_en),
  .pop_en     (pop_en),
  .push_data  (push_data),
  .pop_data   (pop_data),
  .stk_flat   (stk_flat)
);

// File: tb/lifo_stack_tb_top.sv
module lifo_stack_tb_top;

  localparam int BW = 22;
  localparam int BD = 8;
  localparam int SW = 4;
  localparam int SD = 3;

  logic clk;
  logic rst_n;
  logic b_push, b_pop;
  logic [BW-1:0] b_din, b_dout;
  logic s_push, s_pop;
  logic [SW-1:0] s_din, s_dout;

  int checks;
  int errors;
  bit done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  lifo_stack dut_i (
    .clk (clk), .rst_n (rst_n), .push_en (b_push), .pop_en (b_pop),
    .push_data (b_din), .pop_data (b_dout)
  );

  lifo_stack #(.DEPTH(SD), .WIDTH(SW)) dut_small_i (
    .clk (clk), .rst_n (rst_n), .push_en (s_push), .pop_en (s_pop),
    .push_data (s_din), .pop_data (s_dout)
  );

  function automatic logic [BW-1:0] val(input int k);
    return BW'(32'h2A5000 + k * 37);
  endfunction

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic pu, input logic po, input logic [BW-1:0] d);
    @(negedge clk);
    b_push = pu;
    b_pop  = po;
    b_din  = d;
  endtask

  logic [SW-1:0] model [SD];

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    b_push = 0; b_pop = 0; b_din = '0;
    s_push = 0; s_pop = 0; s_din = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset top", b_dout, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: pops after reset yield zero
    for (int j = 0; j < 3; j++) begin
      drive(1'b0, 1'b1, '0);
      @(negedge clk);
      chk("R1 pop after reset", b_dout, '0);
    end

    // R2/R4: twelve pushes, top checked after each
    for (int k = 1; k <= 12; k++) begin
      drive(1'b1, 1'b0, val(k));
      @(posedge clk);
      #1 chk("R2 push top", b_dout, val(k));
    end

    // R3/R4/R5: twelve pops; oldest four lost, then deepest repeats
    for (int j = 0; j < 12; j++) begin
      int idx;
      idx = (12 - j > 5) ? 12 - j : 5;
      drive(1'b0, 1'b1, '0);
      #1 chk((j < 8) ? "R3 pop order" : "R5 underflow repeat", b_dout, val(idx));
      if (j == 7) chk("R4 oldest lost", b_dout, val(5));
    end
    drive(1'b0, 1'b0, '0);
    #1 chk("R5 deepest kept", b_dout, val(5));

    // R6: push two, then push+pop swaps top only
    drive(1'b1, 1'b0, val(100));
    drive(1'b1, 1'b0, val(101));
    drive(1'b1, 1'b1, val(200));
    drive(1'b0, 1'b0, '0);
    #1 chk("R6 swap top", b_dout, val(200));
    // R8: pop output shows top in the same cycle as the strobe
    drive(1'b0, 1'b1, '0);
    #1 chk("R8 same-cycle top", b_dout, val(200));
    drive(1'b0, 1'b0, '0);
    #1 chk("R6 second unchanged", b_dout, val(100));

    // R7: idle holds
    repeat (5) @(negedge clk);
    chk("R7 idle hold", b_dout, val(100));

    // R9: asynchronous clear, then release latency
    #1 rst_n = 1'b0;
    #0.5 chk("R9 async clear", b_dout, '0);
    @(negedge clk);
    rst_n = 1'b1;
    b_push = 1'b1; b_pop = 1'b0; b_din = val(300);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R9 strobes ignored during release", b_dout, '0);
    @(posedge clk);
    #1 chk("R9 push at third edge", b_dout, val(300));
    drive(1'b0, 1'b0, '0);

    // Small configuration: random walk against a shift model
    for (int i = 0; i < SD; i++) model[i] = '0;
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int n = 0; n < 20000; n++) begin
        @(negedge clk);
        checks++;
        if (s_dout !== model[0]) begin
          errors++;
          $display("FAIL R3 R4 R5 R6 R7 small model actual %0h expected %0h", s_dout, model[0]);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s_push = lfsr[0];
        s_pop  = lfsr[3];
        s_din  = SW'(n);
        if (s_push && s_pop) begin
          model[0] = s_din;
        end else if (s_push) begin
          for (int i = SD - 1; i > 0; i--) model[i] = model[i-1];
          model[0] = s_din;
        end else if (s_pop) begin
          for (int i = 0; i < SD - 1; i++) model[i] = model[i+1];
        end
      end
    end
    s_push = 0; s_pop = 0;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule